// File: doc/BRIEF.md
# Multi-style graphic LCD bus bridge

This block sits between an internal requester and the bus of a graphic LCD controller chip. Each request carries one byte, a flag that marks it as display data or as a command, and a read/write flag. The bridge turns the request into one complete bus cycle on the pins that face the panel. Two static configuration inputs pick the signalling style: a parallel bus with separate active-low read and write strobes, a parallel bus with an active-high enable and a read/write direction pin, or a two-wire write-only serial link carried on the top two data lines.

Every setup, strobe, hold, serial half-period and idle-gap length is a parameter counted in clock cycles. After its own reset, the bridge holds the panel reset low for a parameterised time and refuses requests until that time has passed. A parallel read returns the sampled byte with the completion pulse. A read asked for in serial style completes at once with an error and leaves the bus untouched. The configuration inputs are meant to change only while the bridge is in reset.

Top module: `lcd_host_bridge`

## Requirements
- R1: After `rst` is released, `lcd_rst_n` stays low for exactly RST_CYC clock edges and then goes high; `req_ready` stays low until `lcd_rst_n` is high.
- R2: `lcd_cs_n` is high and `lcd_data_oe` is all zeros whenever no transaction is in progress; `lcd_cs_n` is low for the whole of each bus transaction.
- R3: With `bus_par_sel`=1 and `bus_m68_sel`=0 (strobe style), a write drives `lcd_wr_rw` low for exactly STROBE_CYC cycles while `lcd_rd_e` stays high, and the byte stays driven on `lcd_data_o` with `lcd_data_oe`=8'hFF after the rising edge of the write strobe.
- R4: In strobe style a read drives `lcd_rd_e` low for STROBE_CYC cycles with `lcd_data_oe`=0, and `rsp_rdata` holds the byte present on `lcd_data_i` during the final strobe-low cycle when `rsp_done` pulses.
- R5: With `bus_par_sel`=1 and `bus_m68_sel`=1 (enable style), `lcd_rd_e` is an active-high enable pulse of STROBE_CYC cycles, `lcd_wr_rw` is 1 for a read and 0 for a write and does not change while the enable is high, and reads return the byte present before the enable falls.
- R6: With `bus_par_sel`=0 (serial style), a write shifts the byte most significant bit first on `lcd_data_o[7]`, with the clock on `lcd_data_o[6]`; each bit is set up while the clock is low and is taken on its rising edge. There are exactly 8 rising edges while `lcd_cs_n` is low, `lcd_data_oe[5:0]` stays 0, and `lcd_rd_e` and `lcd_wr_rw` stay high.
- R7: In serial style a read request is accepted and answered in the next cycle with `rsp_done`=1 and `rsp_err`=1, and `lcd_cs_n` never goes low for it.
- R8: `rsp_done` is a one-cycle pulse per accepted request; `req_ready` is low while a bus transaction is in progress; `rsp_err` is 0 for every completed bus transaction.
- R9: Between two bus transactions `lcd_cs_n` stays high for at least GAP_CYC cycles.
- R10: `lcd_dc` is 1 for display data (`req_dc`=1) and 0 for commands, and does not change while `lcd_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_par_sel | input | 1 | 1: parallel bus, 0: serial link (static) |
| bus_m68_sel | input | 1 | Parallel style: 1 enable/direction, 0 separate strobes (static) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_rd | input | 1 | 1: read, 0: write |
| req_dc | input | 1 | 1: display data, 0: command |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request rejected (serial read) |
| rsp_rdata | output | 8 | Byte read from the controller |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_dc | output | 1 | Data/command select |
| lcd_rd_e | output | 1 | Read strobe (active low) or enable (active high) |
| lcd_wr_rw | output | 1 | Write strobe (active low) or read/write direction |
| lcd_data_o | output | 8 | Data bus drive value |
| lcd_data_oe | output | 8 | Per-bit data bus output enable |
| lcd_data_i | input | 8 | Data bus sampled value |
| lcd_rst_n | output | 1 | Panel reset, active low |

## Verification
The assertions assume that `bus_par_sel` and `bus_m68_sel` hold still outside reset. They also assume that a requester keeps `req_valid` and its payload steady until the request is taken, so that the serial-read rejection check sees exactly one acceptance. The bench changes the style inputs only while `rst` is high. It drops `req_valid` on the first falling edge after acceptance, and a panel model drives `lcd_data_i` only while a read strobe or read enable is active. If the bridge sampled too late, it would see zero.

// File: rtl/lcd_bridge_pkg.sv
package lcd_bridge_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_RST,
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_SLO,
    ST_SHI,
    ST_HOLD,
    ST_GAP
  } br_state_t;

  // returns {rd_or_enable, wr_or_direction}
  function automatic logic [1:0] pin_levels(input logic par, input logic m68,
                                            input logic act, input logic stb,
                                            input logic rd);
    logic [1:0] lv;
    if (!par)      lv = 2'b11;
    else if (m68)  lv = {stb, (act ? rd : 1'b1)};
    else           lv = {~(stb & rd), ~(stb & ~rd)};
    return lv;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_rst_gen.sv
module lcd_rst_gen #(
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  output logic rst_done
);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam logic [RW-1:0] LAST = RW'(RST_CYC - 1);

  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      rst_done <= 1'b0;
    end else if (!rst_done) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) rst_done <= 1'b1;
    end
  end
endmodule

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/lcd_serial_tx.sv
module lcd_serial_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_byte,
  input  logic          shift,
  output logic          bit_out,
  output logic          last_bit
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] sh;
  logic [CW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      idx <= '0;
    end else if (load) begin
      sh  <= load_byte;
      idx <= '0;
    end else if (shift) begin
      sh  <= {sh[DW-2:0], 1'b0};
      idx <= idx + 1'b1;
    end
  end

  assign bit_out  = sh[DW-1];
  assign last_bit = (idx == LAST);
endmodule

// File: rtl/lcd_host_bridge.sv
module lcd_host_bridge
  import lcd_bridge_pkg::*;
#(
  parameter int DW         = 8,
  parameter int RST_CYC    = 16,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 4,
  parameter int HOLD_CYC   = 2,
  parameter int GAP_CYC    = 4,
  parameter int SCK_HALF   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_par_sel,
  input  logic          bus_m68_sel,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_rd,
  input  logic          req_dc,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          lcd_cs_n,
  output logic          lcd_dc,
  output logic          lcd_rd_e,
  output logic          lcd_wr_rw,
  output logic [DW-1:0] lcd_data_o,
  output logic [DW-1:0] lcd_data_oe,
  input  logic [DW-1:0] lcd_data_i,
  output logic          lcd_rst_n
);
  localparam int MAXC = max_of(max_of(max_of(SETUP_CYC, STROBE_CYC), max_of(HOLD_CYC, GAP_CYC)), SCK_HALF);
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] L_SETUP  = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] L_STROBE = TW'(STROBE_CYC - 1);
  localparam logic [TW-1:0] L_HOLD   = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] L_GAP    = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] L_HALF   = TW'(SCK_HALF - 1);
  localparam logic [DW-1:0] SER_OE   = {2'b11, {(DW-2){1'b0}}};

  br_state_t     state;
  logic          rst_done;
  logic          t_load, t_zero;
  logic [TW-1:0] t_val;
  logic          sh_load, sh_shift, sh_bit, sh_last;
  logic          take, take_bus, take_reject;
  logic          act_q, stb_q, isrd_q, scl_q;
  logic [DW-1:0] pdata_q;
  logic [1:0]    pins;

  lcd_rst_gen #(.RST_CYC(RST_CYC)) u_rst (
    .clk(clk), .rst(rst), .rst_done(rst_done));

  lcd_phase_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_zero));

  lcd_serial_tx #(.DW(DW)) u_ser (
    .clk(clk), .rst(rst), .load(sh_load), .load_byte(req_wdata),
    .shift(sh_shift), .bit_out(sh_bit), .last_bit(sh_last));

  assign req_ready   = (state == ST_IDLE);
  assign take        = req_valid && req_ready;
  assign take_reject = take && !bus_par_sel && req_rd;
  assign take_bus    = take && !take_reject;
  assign sh_load     = take_bus && !bus_par_sel;
  assign sh_shift    = (state == ST_SHI) && t_zero && !sh_last;

  // timer reload on each phase change
  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    unique case (state)
      ST_IDLE:   if (take_bus) begin t_load = 1'b1; t_val = bus_par_sel ? L_SETUP : L_HALF; end
      ST_SETUP:  if (t_zero) begin t_load = 1'b1; t_val = L_STROBE; end
      ST_STROBE: if (t_zero) begin t_load = 1'b1; t_val = L_HOLD; end
      ST_SLO:    if (t_zero) begin t_load = 1'b1; t_val = L_HALF; end
      ST_SHI:    if (t_zero) begin t_load = 1'b1; t_val = sh_last ? L_HOLD : L_HALF; end
      ST_HOLD:   if (t_zero) begin t_load = 1'b1; t_val = L_GAP; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_WAIT_RST;
      lcd_cs_n    <= 1'b1;
      lcd_dc      <= 1'b0;
      act_q       <= 1'b0;
      stb_q       <= 1'b0;
      isrd_q      <= 1'b0;
      scl_q       <= 1'b0;
      pdata_q     <= '0;
      lcd_data_oe <= '0;
      rsp_done    <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      unique case (state)
        ST_WAIT_RST: if (rst_done) state <= ST_IDLE;
        ST_IDLE: begin
          if (take_reject) begin
            rsp_done <= 1'b1;
            rsp_err  <= 1'b1;
          end else if (take_bus) begin
            lcd_cs_n    <= 1'b0;
            lcd_dc      <= req_dc;
            act_q       <= 1'b1;
            isrd_q      <= req_rd;
            pdata_q     <= req_wdata;
            scl_q       <= 1'b0;
            if (req_rd)           lcd_data_oe <= '0;
            else if (bus_par_sel) lcd_data_oe <= '1;
            else                  lcd_data_oe <= SER_OE;
            state <= bus_par_sel ? ST_SETUP : ST_SLO;
          end
        end
        ST_SETUP: if (t_zero) begin
          stb_q <= 1'b1;
          state <= ST_STROBE;
        end
        ST_STROBE: if (t_zero) begin
          if (isrd_q) rsp_rdata <= lcd_data_i;
          stb_q <= 1'b0;
          state <= ST_HOLD;
        end
        ST_SLO: if (t_zero) begin
          scl_q <= 1'b1;
          state <= ST_SHI;
        end
        ST_SHI: if (t_zero) begin
          scl_q <= 1'b0;
          state <= sh_last ? ST_HOLD : ST_SLO;
        end
        ST_HOLD: if (t_zero) begin
          lcd_cs_n    <= 1'b1;
          lcd_data_oe <= '0;
          act_q       <= 1'b0;
          isrd_q      <= 1'b0;
          rsp_done    <= 1'b1;
          state       <= ST_GAP;
        end
        ST_GAP: if (t_zero) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pins       = pin_levels(bus_par_sel, bus_m68_sel, act_q, stb_q, isrd_q);
  assign lcd_rd_e   = pins[1];
  assign lcd_wr_rw  = pins[0];
  assign lcd_data_o = bus_par_sel ? pdata_q : {sh_bit, scl_q, {(DW-2){1'b0}}};
  assign lcd_rst_n  = rst_done;

endmodule

// File: rtl/lcd_host_bridge_chk.sv
module lcd_host_bridge_chk #(
  parameter int DW      = 8,
  parameter int RST_CYC = 16,
  parameter int GAP_CYC = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_par_sel,
  input logic          bus_m68_sel,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_rd,
  input logic          rsp_done,
  input logic          rsp_err,
  input logic          lcd_cs_n,
  input logic          lcd_dc,
  input logic          lcd_rd_e,
  input logic          lcd_wr_rw,
  input logic [DW-1:0] lcd_data_oe,
  input logic          lcd_rst_n
);
  localparam int CW = $clog2(RST_CYC + GAP_CYC + 2);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] since_rst, hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      hi_run    <= CMAX;
    end else begin
      if (since_rst != CMAX) since_rst <= since_rst + 1'b1;
      if (!lcd_cs_n)         hi_run <= '0;
      else if (hi_run != CMAX) hi_run <= hi_run + 1'b1;
    end
  end

  p_rst_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (since_rst < CW'(RST_CYC)) |-> (!lcd_rst_n && !req_ready));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    lcd_cs_n |-> (lcd_data_oe == '0));

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_par_sel && !bus_m68_sel) |-> (lcd_rd_e || lcd_wr_rw));

  p_read_nodrive_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_par_sel && !bus_m68_sel && !lcd_rd_e) |-> (lcd_data_oe == '0));

  p_dir_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_par_sel && bus_m68_sel && lcd_rd_e && $past(lcd_rd_e)) |-> $stable(lcd_wr_rw));

  p_serial_pins_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_par_sel |-> (lcd_rd_e && lcd_wr_rw && (lcd_data_oe[DW-3:0] == '0)));

  p_serial_read_err_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_rd && !bus_par_sel) |=> (rsp_done && rsp_err && lcd_cs_n));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
    !lcd_cs_n |-> !req_ready);

  p_gap_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_cs_n) |-> (hi_run >= CW'(GAP_CYC)));

  p_dc_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (!lcd_cs_n && !$past(lcd_cs_n)) |-> $stable(lcd_dc));

endmodule

bind lcd_host_bridge lcd_host_bridge_chk #(.DW(DW), .RST_CYC(RST_CYC), .GAP_CYC(GAP_CYC)) u_chk (.*);

// File: tb/lcd_host_bridge_tb.sv
module lcd_host_bridge_tb;
  localparam int RST_CYC = 6, SETUP = 2, STROBE = 3, HOLD = 2, GAP = 3, HALF = 2;

  logic clk = 0, rst = 1;
  logic par = 1, m68 = 0;
  logic req_valid = 0, req_rd = 0, req_dc = 0;
  logic [7:0] req_wdata = 0, dev_val = 8'h00;
  logic req_ready, rsp_done, rsp_err, lcd_cs_n, lcd_dc, lcd_rd_e, lcd_wr_rw, lcd_rst_n;
  logic [7:0] rsp_rdata, lcd_data_o, lcd_data_oe, lcd_data_i;
  logic rd_act;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [9:0] expq[$];   // {is_read, dc, byte}

  always #4 clk = ~clk;

  lcd_host_bridge #(.RST_CYC(RST_CYC), .SETUP_CYC(SETUP), .STROBE_CYC(STROBE),
    .HOLD_CYC(HOLD), .GAP_CYC(GAP), .SCK_HALF(HALF)) u_dut (
    .clk(clk), .rst(rst), .bus_par_sel(par), .bus_m68_sel(m68),
    .req_valid(req_valid), .req_ready(req_ready), .req_rd(req_rd), .req_dc(req_dc),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc), .lcd_rd_e(lcd_rd_e), .lcd_wr_rw(lcd_wr_rw),
    .lcd_data_o(lcd_data_o), .lcd_data_oe(lcd_data_oe), .lcd_data_i(lcd_data_i),
    .lcd_rst_n(lcd_rst_n));

  // panel model: drives the bus only while a read is being strobed
  assign rd_act     = par && !lcd_cs_n && (m68 ? (lcd_rd_e && lcd_wr_rw) : !lcd_rd_e);
  assign lcd_data_i = rd_act ? dev_val : 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- monitor / scoreboard ----------------
  logic p_cs = 1, p_scl = 0, p_stb = 0, p_rd8080 = 1;
  int wid = 0, gap = 1000, nb = 0, cs_falls = 0;
  logic [7:0] sbyte = 0;

  task automatic score(input logic is_rd, input logic dc, input logic [7:0] d);
    logic [9:0] e;
    if (expq.size() == 0) begin
      check(0, "R2 unexpected bus cycle", {is_rd, dc, d}, 0);
      return;
    end
    e = expq.pop_front();
    check(e[9] == is_rd, "R5 direction", is_rd, e[9]);
    check(e[8] == dc, "R10 dc level", dc, e[8]);
    if (!is_rd) check(e[7:0] == d, "R3/R6 write byte", d, e[7:0]);
  endtask

  always @(negedge clk) begin
    logic stb;
    if (rst) begin
      p_cs = 1; p_scl = 0; p_stb = 0; p_rd8080 = 1; wid = 0; gap = 1000; nb = 0;
    end else begin
      if (!lcd_cs_n && p_cs) begin
        cs_falls++;
        check(gap >= GAP, "R9 cs high gap", gap, GAP);
        nb = 0;
      end
      if (lcd_cs_n) gap++; else gap = 0;
      if (lcd_cs_n && !p_cs && !par) check(nb == 8, "R6 eight clocks per frame", nb, 8);
      if (par) begin
        stb = m68 ? lcd_rd_e : (!lcd_rd_e || !lcd_wr_rw);
        if (stb) wid++;
        if (p_stb && !stb) begin
          check(wid == STROBE, "R3 strobe width", wid, STROBE);
          check(!lcd_cs_n, "R2 cs low past strobe", lcd_cs_n, 0);
          if (m68) begin
            if (!lcd_wr_rw) check(lcd_data_oe == 8'hFF, "R5 write drive", lcd_data_oe, 8'hFF);
            score(lcd_wr_rw, lcd_dc, lcd_data_o);
          end else begin
            if (p_rd8080) check(lcd_data_oe == 8'hFF, "R3 data held past wr rise", lcd_data_oe, 8'hFF);
            score(!p_rd8080, lcd_dc, lcd_data_o);
          end
          wid = 0;
        end
        p_stb = stb;
        p_rd8080 = lcd_rd_e;
      end else begin
        if (lcd_data_o[6] && !p_scl && !lcd_cs_n) begin
          sbyte = {sbyte[6:0], lcd_data_o[7]};
          nb++;
          if (nb == 8) score(1'b0, lcd_dc, sbyte);
        end
        p_scl = lcd_data_o[6];
      end
      p_cs = lcd_cs_n;
    end
  end

  // ---------------- driver ----------------
  task automatic do_reset(input logic new_par, input logic new_m68);
    int n = 0;
    @(negedge clk);
    rst = 1; par = new_par; m68 = new_m68;
    repeat (3) @(negedge clk);
    check(lcd_cs_n && !lcd_rst_n && !req_ready && lcd_data_oe == 0, "R2 reset state",
          {lcd_cs_n, lcd_rst_n, req_ready}, 3'b100);
    rst = 0;
    do begin
      @(negedge clk);
      n++;
      if (!lcd_rst_n) check(!req_ready, "R1 ready held during panel reset", req_ready, 0);
    end while (!lcd_rst_n && n < 100);
    check(n == RST_CYC, "R1 panel reset length", n, RST_CYC);
    @(negedge clk);
  endtask

  task automatic txn(input logic rd, input logic dc, input logic [7:0] d, input logic [7:0] rval);
    int n = 0;
    logic bus = par || !rd;
    if (bus) expq.push_back({rd, dc, d});
    dev_val = rval;
    req_valid = 1; req_rd = rd; req_dc = dc; req_wdata = d;
    while (!req_ready && n < 200) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 0;
    if (bus) check(!req_ready, "R8 ready low while busy", req_ready, 0);
    n = 0;
    while (!rsp_done && n < 400) begin @(negedge clk); n++; end
    check(rsp_done == 1, "R8 done pulse seen", rsp_done, 1);
    if (!bus) check(n == 0 && rsp_err, "R7 immediate error", {n[3:0], rsp_err}, 1);
    else check(!rsp_err, "R8 no error on bus cycle", rsp_err, 0);
    if (bus && rd) check(rsp_rdata == rval, m68 ? "R5 read byte" : "R4 read byte", rsp_rdata, rval);
    @(negedge clk);
    check(!rsp_done, "R8 done one cycle", rsp_done, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int f0;
    // strobe style
    do_reset(1'b1, 1'b0);
    txn(0, 0, 8'hA5, 0);          // R3 command write, R10 dc low
    txn(0, 1, 8'h3C, 0);          // R10 data write
    txn(1, 1, 0, 8'h5A);          // R4 read
    txn(1, 0, 0, 8'hC3);          // R4 read command side
    txn(0, 1, 8'hFF, 0);          // back to back, R9
    // enable/direction style
    do_reset(1'b1, 1'b1);
    txn(0, 0, 8'h12, 0);          // R5 write
    txn(1, 1, 0, 8'h96);          // R5 read
    txn(0, 1, 8'h00, 0);
    // serial style
    do_reset(1'b0, 1'b0);
    txn(0, 0, 8'h81, 0);          // R6 MSB first
    txn(0, 1, 8'h6E, 0);
    f0 = cs_falls;
    txn(1, 1, 0, 8'h77);          // R7 rejected read
    repeat (4) @(negedge clk);
    check(cs_falls == f0, "R7 no bus activity", cs_falls - f0, 0);
    txn(0, 1, 8'h01, 0);
    repeat (10) @(negedge clk);
    check(expq.size() == 0, "R2 all expected cycles seen", expq.size(), 0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule